// File: doc/BRIEF.md
# Interrupt and break entry sequencer

This block walks an 8-bit processor core through the bus cycles of an exception entry. There are three causes: a maskable interrupt, a non-maskable interrupt and a software break. The block runs one bus cycle per clock. When the core signals an instruction boundary, the sequencer picks the cause with the highest priority and captures the core's program counter, stack pointer and flags. It then owns the 16-bit address bus until a new program counter has been loaded from the vector table.

An entry works in four steps. It issues dummy reads at the program counter. It pushes the return address, high byte first, onto the stack in page one. It pushes a packed status byte and sets the interrupt-mask flag. Last, it reads a two-byte vector, low byte first. A software break makes one dummy read and advances the return address by one byte. If a non-maskable request is pending when the break pushes its status, it takes over the vector fetch and its pending latch is cleared.

The bus never stalls. A read returns `bus_rdata` in the same cycle in which its address is shown, so there is no back-pressure and no handshake. Instruction decode and the arithmetic unit lie outside the block.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held, `busy`, `done`, `bus_we` and `nmi_pending` are 0, and `pc_out` and `sp_out` are 0.
- R2: A request is taken only in a cycle with `at_boundary` high while idle. The priority is pending non-maskable first, then maskable (only when bit 2 of `flags_in` is 0), then software break. A maskable request with bit 2 set, or any request without `at_boundary`, leaves `busy` low.
- R3: A hardware entry lasts seven cycles in this order:
  - two reads at the captured PC;
  - a write of the PC high byte;
  - a write of the PC low byte;
  - a write of the status byte;
  - a read of the vector low byte;
  - a read of the vector high byte.
  
  `bus_we` is 1 only on the three writes.
- R4: Every stack write goes to address 0x0100 OR SP, and SP drops by one after each write, wrapping from 0x00 to 0xFF. After an entry, `sp_out` equals the captured SP minus 3.
- R5: The pushed status byte carries N in bit 7, V in bit 6 and a constant 1 in bit 5. Bit 4 is the break indicator: 0 for a hardware entry and 1 for a software break. D, I, Z and C follow in bits 3 down to 0.
- R6: The mask flag (bit 2 of `flags_out`) is set at the end of the status-write cycle. The pushed byte holds its old value. The other flags keep their captured values, and `flags_out` shows bit 5 as 1 and bit 4 as 0.
- R7: Maskable entries and breaks read their vector at 0xFFFE then 0xFFFF. Non-maskable entries read theirs at 0xFFFA then 0xFFFB. `pc_out` becomes {high byte, low byte}.
- R8: A software break lasts six cycles. It makes one read at PC, then three pushes, then the vector reads. The pushed return address is PC+1 modulo 65536.
- R9: If `nmi_pending` is high during a break's status-write cycle, the break reads the vector at 0xFFFA/0xFFFB and clears `nmi_pending`. An edge that arrives later leaves the 0xFFFE vector in use and stays pending.
- R10: A rising edge on `nmi_in` sets `nmi_pending` in the next cycle. A level that is held high sets it only once. Accepting a non-maskable entry clears it.
- R11: `done` is high for exactly one cycle, the cycle after the vector-high read. In that cycle `busy` is low and `pc_out` already holds the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| at_boundary | input | 1 | Core is at an instruction boundary |
| irq_req | input | 1 | Maskable request, level-sensitive |
| nmi_in | input | 1 | Non-maskable request line, edge-detected |
| brk_req | input | 1 | Core decoded a software break |
| pc_in | input | 16 | Core program counter |
| sp_in | input | 8 | Core stack pointer |
| flags_in | input | 8 | Core flags: N V - - D I Z C (bits 5 and 4 ignored) |
| bus_rdata | input | 8 | Read data for the current bus cycle |
| busy | output | 1 | Sequencer owns the bus |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| flags_out | output | 8 | Updated flags |
| nmi_pending | output | 1 | Non-maskable request latched |
| done | output | 1 | One-cycle pulse when entry completes |

## Verification
The collision that matters is a non-maskable edge landing while a software break is in progress. Either the status push takes the pending request and redirects the vector, or the edge arrives too late and stays latched for the next boundary. The bench raises `nmi_in` on every cycle of a break. It expects a redirect to 0xFFFA with the latch cleared when the edge comes at least one cycle before the status write. Otherwise it expects 0xFFFE with the latch still set, which the next boundary then consumes. A second collision is all three requests present at one boundary. It is judged by which vector is read and by the break bit in the pushed status.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DUM1  = 3'd1,
    ST_DUM2  = 3'd2,
    ST_PSH_H = 3'd3,
    ST_PSH_L = 3'd4,
    ST_PSH_P = 3'd5,
    ST_VEC_L = 3'd6,
    ST_VEC_H = 3'd7
  } seq_state_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IRQ  = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_BRK  = 2'd3
  } entry_src_t;

  // flag bit positions inside the status byte
  localparam int FLG_C   = 0;
  localparam int FLG_Z   = 1;
  localparam int FLG_I   = 2;
  localparam int FLG_D   = 3;
  localparam int FLG_B   = 4;
  localparam int FLG_ONE = 5;
  localparam int FLG_V   = 6;
  localparam int FLG_N   = 7;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic clr,
  output logic pending
);
  logic prev_q;
  logic rise;

  assign rise = nmi_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev_q  <= nmi_in;
      // a fresh edge wins over a clear in the same cycle
      pending <= rise | (pending & ~clr);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              at_boundary,
  input  logic              idle,
  input  logic              nmi_pend,
  input  logic              irq_req,
  input  logic              brk_req,
  input  logic [DATA_W-1:0] flags_in,
  output logic              start,
  output entry_src_t        src
);
  logic irq_ok;

  assign irq_ok = irq_req & ~flags_in[FLG_I];

  always_comb begin
    if (nmi_pend)     src = SRC_NMI;
    else if (irq_ok)  src = SRC_IRQ;
    else if (brk_req) src = SRC_BRK;
    else              src = SRC_NONE;
  end

  assign start = at_boundary & idle & (src != SRC_NONE);
endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] flags,
  input  logic              brk_bit,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] fixed_one;
  logic [DATA_W-1:0] brk_mask;

  always_comb begin
    fixed_one          = '0;
    fixed_one[FLG_ONE] = 1'b1;
    brk_mask           = '0;
    brk_mask[FLG_B]    = brk_bit;
    status             = flags | fixed_one | brk_mask;
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  entry_src_t        src,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              nmi_pend,
  output seq_state_t        state,
  output logic              brk_q,
  output logic              nmi_vec_q,
  output logic              nmi_clr,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0] flags_q,
  output logic              done_q
);
  localparam logic [DATA_W-1:0] ONE_D    = DATA_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);
  localparam logic [DATA_W-1:0] KEEP_MSK = ~(DATA_W'(1) << FLG_B);
  localparam logic [DATA_W-1:0] SET_ONE  = DATA_W'(1) << FLG_ONE;

  logic [DATA_W-1:0] vec_lo_q;
  logic              hijack;

  assign hijack  = (state == ST_PSH_P) & brk_q & nmi_pend;
  assign nmi_clr = (start & (src == SRC_NMI)) | hijack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      brk_q     <= 1'b0;
      nmi_vec_q <= 1'b0;
      pc_q      <= '0;
      sp_q      <= '0;
      flags_q   <= SET_ONE;
      vec_lo_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pc_q      <= pc_in;
            sp_q      <= sp_in;
            flags_q   <= (flags_in | SET_ONE) & KEEP_MSK;
            brk_q     <= (src == SRC_BRK);
            nmi_vec_q <= (src == SRC_NMI);
            state     <= (src == SRC_BRK) ? ST_DUM2 : ST_DUM1;
          end
        end
        ST_DUM1: state <= ST_DUM2;
        ST_DUM2: begin
          if (brk_q) pc_q <= pc_q + ONE_A;
          state <= ST_PSH_H;
        end
        ST_PSH_H: begin
          sp_q  <= sp_q - ONE_D;
          state <= ST_PSH_L;
        end
        ST_PSH_L: begin
          sp_q  <= sp_q - ONE_D;
          state <= ST_PSH_P;
        end
        ST_PSH_P: begin
          sp_q           <= sp_q - ONE_D;
          flags_q[FLG_I] <= 1'b1;
          if (hijack) nmi_vec_q <= 1'b1;
          state <= ST_VEC_L;
        end
        ST_VEC_L: begin
          vec_lo_q <= bus_rdata;
          state    <= ST_VEC_H;
        end
        ST_VEC_H: begin
          pc_q   <= {bus_rdata, vec_lo_q};
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                      ADDR_W     = 16,
  parameter int                      DATA_W     = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0]       VEC_MASK   = 'hFFFE,
  parameter logic [ADDR_W-1:0]       VEC_NONM   = 'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              at_boundary,
  input  logic              irq_req,
  input  logic              nmi_in,
  input  logic              brk_req,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] flags_out,
  output logic              nmi_pending,
  output logic              done
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  seq_state_t        state;
  entry_src_t        src;
  logic              start;
  logic              brk_q;
  logic              nmi_vec_q;
  logic              nmi_clr;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] flags_q;
  logic [DATA_W-1:0] status_byte;
  logic [ADDR_W-1:0] vec_base;
  logic [ADDR_W-1:0] stack_addr;

  irq_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_in  (nmi_in),
    .clr     (nmi_clr),
    .pending (nmi_pending)
  );

  irq_arbiter #(.DATA_W(DATA_W)) u_arb (
    .at_boundary (at_boundary),
    .idle        (state == ST_IDLE),
    .nmi_pend    (nmi_pending),
    .irq_req     (irq_req),
    .brk_req     (brk_req),
    .flags_in    (flags_in),
    .start       (start),
    .src         (src)
  );

  irq_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src       (src),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .flags_in  (flags_in),
    .bus_rdata (bus_rdata),
    .nmi_pend  (nmi_pending),
    .state     (state),
    .brk_q     (brk_q),
    .nmi_vec_q (nmi_vec_q),
    .nmi_clr   (nmi_clr),
    .pc_q      (pc_q),
    .sp_q      (sp_q),
    .flags_q   (flags_q),
    .done_q    (done)
  );

  irq_status_pack #(.DATA_W(DATA_W)) u_pack (
    .flags   (flags_q),
    .brk_bit (brk_q),
    .status  (status_byte)
  );

  assign vec_base   = nmi_vec_q ? VEC_NONM : VEC_MASK;
  assign stack_addr = {STACK_PAGE, sp_q};

  always_comb begin
    bus_addr  = pc_q;
    bus_wdata = '0;
    bus_we    = 1'b0;
    case (state)
      ST_PSH_H: begin
        bus_addr  = stack_addr;
        bus_wdata = pc_q[ADDR_W-1:DATA_W];
        bus_we    = 1'b1;
      end
      ST_PSH_L: begin
        bus_addr  = stack_addr;
        bus_wdata = pc_q[DATA_W-1:0];
        bus_we    = 1'b1;
      end
      ST_PSH_P: begin
        bus_addr  = stack_addr;
        bus_wdata = status_byte;
        bus_we    = 1'b1;
      end
      ST_VEC_L: bus_addr = vec_base;
      ST_VEC_H: bus_addr = vec_base + ONE_A;
      default:  bus_addr = pc_q;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign pc_out    = pc_q;
  assign sp_out    = sp_q;
  assign flags_out = flags_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int                       ADDR_W     = 16,
  parameter int                       DATA_W     = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_in,
  input logic              busy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] sp_out,
  input logic [DATA_W-1:0] flags_out,
  input logic              nmi_pending,
  input logic              done
);
  // R4
  stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R4
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> sp_out == $past(sp_out) - DATA_W'(1));

  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_we);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  mask_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[2]);

  // R10
  nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_in) |=> nmi_pending);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi_in      (nmi_in),
  .busy        (busy),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .sp_out      (sp_out),
  .flags_out   (flags_out),
  .nmi_pending (nmi_pending),
  .done        (done)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
  localparam int K_IRQ = 0;
  localparam int K_NMI = 1;
  localparam int K_BRK = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        at_boundary = 1'b0;
  logic        irq_req = 1'b0;
  logic        nmi_in = 1'b0;
  logic        brk_req = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  flags_in = '0;
  logic [7:0]  bus_rdata;
  logic        busy, bus_we, nmi_pending, done;
  logic [15:0] bus_addr, pc_out;
  logic [7:0]  bus_wdata, sp_out, flags_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
    .nmi_in(nmi_in), .brk_req(brk_req), .pc_in(pc_in), .sp_in(sp_in),
    .flags_in(flags_in), .bus_rdata(bus_rdata), .busy(busy),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .pc_out(pc_out), .sp_out(sp_out), .flags_out(flags_out),
    .nmi_pending(nmi_pending), .done(done)
  );

  // memory model: vector bytes are address low byte XOR 0x5A
  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return (a[15:3] == 13'h1FFF) ? (a[7:0] ^ 8'h5A) : 8'h00;
  endfunction
  assign bus_rdata = mem_f(bus_addr);

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_entry(input int kind, input logic [15:0] pc, input logic [7:0] sp,
                          input logic [7:0] fl, input bit extra, input int nmi_at,
                          input bit pulse, input bit exp_pend);
    logic [15:0] ret, vec, e_addr;
    logic [7:0]  st, e_data;
    bit          brk, hij, e_we;
    int          n, j;
    string       tag;
    brk = (kind == K_BRK);
    hij = brk && (nmi_at >= 0) && (nmi_at <= 2);
    ret = brk ? pc + 16'd1 : pc;
    vec = (kind == K_NMI || hij) ? 16'hFFFA : 16'hFFFE;
    st  = {fl[7:6], 1'b1, brk, fl[3:0]};
    if (pulse) begin
      @(negedge clk); nmi_in = 1'b1;
      @(negedge clk); nmi_in = 1'b0;
    end
    @(negedge clk);
    at_boundary = 1'b1; pc_in = pc; sp_in = sp; flags_in = fl;
    irq_req = (kind == K_IRQ) || extra;
    brk_req = brk || extra;
    @(negedge clk);
    at_boundary = 1'b0; irq_req = 1'b0; brk_req = 1'b0;
    n = brk ? 6 : 7;
    for (int i = 0; i < n; i++) begin
      j = brk ? i + 1 : i;
      e_data = 8'h00; e_we = 1'b0;
      case (j)
        0, 1: begin e_addr = pc; tag = brk ? "R8 dummy read" : "R3 dummy read"; end
        2: begin e_addr = {8'h01, sp}; e_we = 1'b1; e_data = ret[15:8]; tag = "R4 push hi"; end
        3: begin e_addr = {8'h01, sp - 8'd1}; e_we = 1'b1; e_data = ret[7:0]; tag = "R4 push lo"; end
        4: begin e_addr = {8'h01, sp - 8'd2}; e_we = 1'b1; e_data = st; tag = "R5 push status"; end
        5: begin e_addr = vec; tag = hij ? "R9 vector lo" : "R7 vector lo"; end
        default: begin e_addr = vec + 16'd1; tag = hij ? "R9 vector hi" : "R7 vector hi"; end
      endcase
      chk($sformatf("%s addr", tag), bus_addr, e_addr);
      chk($sformatf("R3 we step %0d", j), {15'd0, bus_we}, {15'd0, e_we});
      if (e_we) chk($sformatf("%s data", tag), {8'd0, bus_wdata}, {8'd0, e_data});
      if (i == nmi_at) nmi_in = 1'b1;
      if (nmi_at >= 0 && i == nmi_at + 1) nmi_in = 1'b0;
      @(negedge clk);
    end
    nmi_in = 1'b0;
    chk("R11 done pulse", {15'd0, done}, 16'd1);
    chk("R11 busy low at done", {15'd0, busy}, 16'd0);
    chk("R7 pc_out vector", pc_out, {mem_f(vec + 16'd1), mem_f(vec)});
    chk("R4 sp_out", {8'd0, sp_out}, {8'd0, sp - 8'd3});
    chk("R6 flags_out", {8'd0, flags_out}, {8'd0, fl[7:6], 2'b10, fl[3], 1'b1, fl[1:0]});
    chk("R9 R10 nmi_pending after entry", {15'd0, nmi_pending}, {15'd0, exp_pend});
    @(negedge clk);
    chk("R11 done single", {15'd0, done}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] pcs [4];
    logic [7:0]  sps [5];
    logic [7:0]  fls [4];
    pcs = '{16'h0000, 16'h1234, 16'hFFFF, 16'h80FF};
    sps = '{8'h00, 8'h01, 8'h02, 8'h80, 8'hFF};
    fls = '{8'h00, 8'hFF, 8'hC3, 8'h0C};

    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 we", {15'd0, bus_we}, 16'd0);
    chk("R1 nmi_pending", {15'd0, nmi_pending}, 16'd0);
    chk("R1 pc_out", pc_out, 16'h0000);
    chk("R1 sp_out", {8'd0, sp_out}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 masked maskable request is ignored
    at_boundary = 1'b1; irq_req = 1'b1; flags_in = 8'h04;
    @(negedge clk); at_boundary = 1'b0;
    chk("R2 masked irq ignored", {15'd0, busy}, 16'd0);
    // R2 request off boundary is ignored
    flags_in = 8'h00; brk_req = 1'b1;
    @(negedge clk);
    chk("R2 no boundary ignored", {15'd0, busy}, 16'd0);
    irq_req = 1'b0; brk_req = 1'b0;
    @(negedge clk);

    // sweep every cause over pc, sp and flag patterns
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 4; a++)
        for (int s = 0; s < 5; s++)
          for (int f = 0; f < 4; f++)
            do_entry(k, pcs[a], sps[s], (k == K_IRQ) ? (fls[f] & 8'hFB) : fls[f],
                     1'b0, -1, (k == K_NMI), 1'b0);

    // R2 priority: nmi over irq and break, irq over break
    do_entry(K_NMI, 16'h4000, 8'hF0, 8'h00, 1'b1, -1, 1'b1, 1'b0);
    do_entry(K_IRQ, 16'h4100, 8'hF0, 8'h81, 1'b1, -1, 1'b0, 1'b0);

    // R9 nmi edge at each cycle of a break
    for (int t = 0; t < 6; t++) begin
      do_entry(K_BRK, 16'h2345, 8'h10, 8'h40, 1'b0, t, 1'b0, (t > 2));
      if (t > 2) do_entry(K_NMI, 16'hA5A4, 8'h0D, 8'h00, 1'b0, -1, 1'b0, 1'b0);
    end

    // R10 held level latches once
    @(negedge clk); nmi_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pending on edge", {15'd0, nmi_pending}, 16'd1);
    at_boundary = 1'b1; pc_in = 16'h0300; sp_in = 8'h50; flags_in = 8'h00;
    @(negedge clk); at_boundary = 1'b0;
    chk("R2 nmi accepted", {15'd0, busy}, 16'd1);
    chk("R10 cleared on accept", {15'd0, nmi_pending}, 16'd0);
    repeat (10) @(negedge clk);
    chk("R10 held level no relatch", {15'd0, nmi_pending}, 16'd0);
    chk("R7 held nmi vector", pc_out, 16'hA1A0);
    at_boundary = 1'b1;
    @(negedge clk); at_boundary = 1'b0;
    chk("R10 no second entry", {15'd0, busy}, 16'd0);
    nmi_in = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule